// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps wall-clock time and calendar date. It advances once for each pulse on a one-second tick input. Two 32-bit words can be read at any time. The time word holds hours, minutes and seconds. The date word holds day, month, a year offset counted from 1970 and a leap flag. At midnight the date moves forward using the length of the current month. When the year changes, the leap flag is computed again.

Software changes either word with a one-cycle write strobe that carries a word select and the new value. The new value is not applied at once. It is held as pending, and a busy bit for that word goes high. The value is loaded into the counter on the second tick after the write. On that tick the busy bit clears, and the loaded value replaces the normal advance of that word. Only one write can be pending at a time. Any write made while a busy bit is set is discarded.

Top module: `cal_clock`

## Requirements
- R1: After reset the time word reads 0 (00:00:00) and the date word reads 0x0000_0101: day 1, month 1, year offset 0, leap flag 0. Busy reads 0.
- R2: Time word layout: seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16, all other bits 0. Each tick increments seconds. Seconds go from 59 to 0 and carry into minutes, minutes go from 59 to 0 and carry into hours, and hours go from 23 to 0.
- R3: Date word layout: day in bits 4:0, month (1 to 12) in bits 11:8, year offset in bits 21:16, leap flag in bit 22, all other bits 0. A tick that takes the time from 23:59:59 to 00:00:00 advances the day. After the last day of the month the day returns to 1 and the month increments. Months 4, 6, 9 and 11 have 30 days. Months 1, 3, 5, 7, 8, 10 and 12 have 31 days.
- R4: February has 29 days when the leap flag is 1 and 28 days when it is 0.
- R5: After December 31 the date becomes January 1 and the year offset increments. The leap flag is set to 1 exactly when (new offset + 1970) is divisible by 4. An offset of 63 (year 2033) wraps to 0.
- R6: A write with wr_sel=0 targets the time word and sets busy bit 0. A write with wr_sel=1 targets the date word and sets busy bit 1. The busy bit is visible in the cycle after the write, provided no busy bit was set when the write was made.
- R7: The written value, with unused bits ignored, appears in the target word on the second tick after the write, and the busy bit clears on that same tick. Until then the target word keeps counting normally.
- R8: A write made while either busy bit is set has no effect. The pending value, the busy bits and both words behave as if the write had not occurred.
- R9: In cycles without a tick, both words and the busy bits hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 selects the time word, 1 selects the date word |
| wr_data | input | 32 | Value to write, in the layout of the target word |
| time_word | output | 32 | Current hours, minutes and seconds |
| date_word | output | 32 | Current leap flag, year offset, month and day |
| busy | output | 2 | Bit 0: time write pending. Bit 1: date write pending |

## Verification
A wrong count register shows on the next tick as a wrong field in a time or date word. A wrong month-length or leap decode stays hidden until a midnight carry at a month or year boundary. For that reason the bench places the calendar just before each such boundary and then runs across it. A wrong commit counter shows as a busy bit clearing one tick early or late, with the new value loaded in the same cycle. Every port is compared against a behavioural model on every clock, so any of these faults is reported in the cycle in which it first appears.

// File: rtl/cal_clock.sv
module cal_clock #(
  parameter int COMMIT_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] time_word,
  output logic [31:0] date_word,
  output logic [1:0]  busy
);
  localparam int CW = $clog2(COMMIT_TICKS + 1);

  logic [5:0]  sec_q, min_q, yr_q;
  logic [4:0]  hr_q, day_q, mlen;
  logic [3:0]  mon_q;
  logic        leap_q;
  logic        pend_q, sel_q;
  logic [22:0] data_q;
  logic [CW-1:0] left_q;

  wire commit   = tick & pend_q & (left_q == CW'(1));
  wire commit_t = commit & ~sel_q;
  wire commit_d = commit & sel_q;
  wire sec_wrap = sec_q >= 6'd59;
  wire min_wrap = min_q >= 6'd59;
  wire hr_wrap  = hr_q >= 5'd23;
  wire day_carry = tick & sec_wrap & min_wrap & hr_wrap & ~commit_t;
  wire day_wrap = day_q >= mlen;
  wire mon_wrap = mon_q >= 4'd12;
  wire [5:0] yr_next = yr_q + 6'd1;

  always_comb begin
    case (mon_q)
      4'd2:                      mlen = leap_q ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   mlen = 5'd30;
      default:                   mlen = 5'd31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0; min_q <= '0; hr_q <= '0;
    end else if (commit_t) begin
      sec_q <= data_q[5:0];
      min_q <= data_q[13:8];
      hr_q  <= data_q[20:16];
    end else if (tick) begin
      sec_q <= sec_wrap ? 6'd0 : sec_q + 6'd1;
      if (sec_wrap) min_q <= min_wrap ? 6'd0 : min_q + 6'd1;
      if (sec_wrap && min_wrap) hr_q <= hr_wrap ? 5'd0 : hr_q + 5'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day_q <= 5'd1; mon_q <= 4'd1; yr_q <= '0; leap_q <= 1'b0;
    end else if (commit_d) begin
      day_q  <= data_q[4:0];
      mon_q  <= data_q[11:8];
      yr_q   <= data_q[21:16];
      leap_q <= data_q[22];
    end else if (day_carry) begin
      if (day_wrap) begin
        day_q <= 5'd1;
        if (mon_wrap) begin
          mon_q  <= 4'd1;
          yr_q   <= yr_next;
          leap_q <= (yr_next[1:0] == 2'd2);
        end else begin
          mon_q <= mon_q + 4'd1;
        end
      end else begin
        day_q <= day_q + 5'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0; sel_q <= 1'b0; data_q <= '0; left_q <= '0;
    end else if (wr_en && !pend_q) begin
      pend_q <= 1'b1;
      sel_q  <= wr_sel;
      data_q <= wr_data[22:0];
      left_q <= CW'(COMMIT_TICKS);
    end else if (tick && pend_q) begin
      left_q <= left_q - CW'(1);
      if (left_q == CW'(1)) pend_q <= 1'b0;
    end
  end

  assign time_word = {11'd0, hr_q, 2'd0, min_q, 2'd0, sec_q};
  assign date_word = {9'd0, leap_q, yr_q, 4'd0, mon_q, 3'd0, day_q};
  assign busy      = {pend_q & sel_q, pend_q & ~sel_q};

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && busy == 2'b00 && time_word[5:0] == 6'd59 |=> time_word[5:0] == 6'd0); // R2
  AST_FEB_LEAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && busy == 2'b00 && time_word == 32'h0017_3B3B && date_word == 32'h0040_021C
    |=> date_word[4:0] == 5'd29); // R4
  AST_YEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && busy == 2'b00 && time_word == 32'h0017_3B3B && date_word[11:0] == 12'hC1F
    |=> date_word[11:0] == 12'h101 && date_word[21:16] == $past(date_word[21:16]) + 6'd1); // R5
  AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && busy == 2'b00 |=> busy != 2'b00); // R6
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|busy) |-> $past(tick)); // R7
  AST_DROP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && busy != 2'b00 |=> $stable(data_q)); // R8
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(time_word) && $stable(date_word)); // R9
endmodule

// File: tb/cal_clock_tb.sv
module cal_clock_tb;
  logic        clk = 0, rst_n = 0, tick = 0, wr_en = 0, wr_sel = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] time_word, date_word;
  logic [1:0]  busy;

  cal_clock u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
                   .wr_data(wr_data), .time_word(time_word), .date_word(date_word), .busy(busy));

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  int s, m, h, d, mo, y, lp, pv, psel, pc;
  logic [31:0] pdata;

  function automatic logic [31:0] mk_time(int hh, int mm, int ss);
    return {11'd0, 5'(hh), 2'd0, 6'(mm), 2'd0, 6'(ss)};
  endfunction
  function automatic logic [31:0] mk_date(int yy, int mn, int dd, int l);
    return {9'd0, 1'(l), 6'(yy), 4'd0, 4'(mn), 3'd0, 5'(dd)};
  endfunction
  function automatic int mdays(int mn, int l);
    if (mn == 2) return l ? 29 : 28;
    if (mn == 4 || mn == 6 || mn == 9 || mn == 11) return 30;
    return 31;
  endfunction

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", t, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      s = 0; m = 0; h = 0; d = 1; mo = 1; y = 0; lp = 0; pv = 0; psel = 0; pc = 0; pdata = '0;
    end else begin
      automatic bit ct = tick && pv && psel == 0 && pc == 1;
      automatic bit cd = tick && pv && psel == 1 && pc == 1;
      automatic bit was_pend = pv != 0;
      automatic bit carry = 0;
      if (tick && !ct) begin
        s++;
        if (s == 60) begin
          s = 0; m++;
          if (m == 60) begin
            m = 0; h++;
            if (h == 24) begin h = 0; carry = 1; end
          end
        end
      end
      if (ct) begin s = pdata[5:0]; m = pdata[13:8]; h = pdata[20:16]; end
      if (cd) begin
        d = pdata[4:0]; mo = pdata[11:8]; y = pdata[21:16]; lp = pdata[22];
      end else if (carry) begin
        d++;
        if (d > mdays(mo, lp)) begin
          d = 1; mo++;
          if (mo > 12) begin
            mo = 1; y = (y + 1) % 64;
            lp = ((y + 1970) % 4 == 0) ? 1 : 0;
          end
        end
      end
      if (wr_en && !was_pend) begin
        pv = 1; psel = wr_sel; pdata = wr_data; pc = 2;
      end else if (tick && was_pend) begin
        pc--;
        if (pc == 0) pv = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag, "time", time_word, mk_time(h, m, s));
      chk(tag, "date", date_word, mk_date(y, mo, d, lp));
      chk(tag, "busy", {30'd0, busy}, {30'd0, 1'(pv && psel == 1), 1'(pv && psel == 0)});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(bit sel, logic [31:0] v);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = v;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask
  task automatic ticks(int n);
    @(negedge clk); tick = 1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); tick = 0;
  endtask
  task automatic set_dt(int yy, int mn, int dd, int l, int hh, int mm, int ss);
    wr(1, mk_date(yy, mn, dd, l)); ticks(2);
    wr(0, mk_time(hh, mm, ss)); ticks(2);
  endtask

  initial begin
    logic [31:0] held_t, held_d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset time", time_word, 32'h0);
    chk("R1", "reset date", date_word, 32'h0000_0101);
    chk("R1", "reset busy", {30'd0, busy}, 32'h0);

    tag = "R2"; ticks(150);
    chk("R2", "2m30s", time_word, mk_time(0, 2, 30));

    tag = "R6"; wr(0, 32'hFFE0_0000 | mk_time(23, 59, 57));
    chk("R6", "time busy", {30'd0, busy}, 32'd1);
    chk("R7", "not yet applied", time_word, mk_time(0, 2, 30));
    tag = "R7"; ticks(1);
    chk("R7", "one tick", time_word, mk_time(0, 2, 31));
    ticks(1);
    chk("R7", "committed", time_word, mk_time(23, 59, 57));
    chk("R7", "busy clear", {30'd0, busy}, 32'd0);
    tag = "R6"; wr(1, mk_date(0, 4, 30, 0));
    chk("R6", "date busy", {30'd0, busy}, 32'd2);
    ticks(2);

    tag = "R3"; set_dt(0, 4, 30, 0, 23, 59, 58); ticks(3);
    chk("R3", "apr30", date_word, mk_date(0, 5, 1, 0));
    chk("R2", "after midnight", time_word, mk_time(0, 0, 1));
    set_dt(0, 1, 31, 0, 23, 59, 58); ticks(3);
    chk("R3", "jan31", date_word, mk_date(0, 2, 1, 0));
    set_dt(0, 1, 15, 0, 23, 59, 58); ticks(3);
    chk("R3", "mid month", date_word, mk_date(0, 1, 16, 0));

    tag = "R4"; set_dt(0, 2, 28, 0, 23, 59, 58); ticks(3);
    chk("R4", "feb28 common", date_word, mk_date(0, 3, 1, 0));
    set_dt(2, 2, 28, 1, 23, 59, 58); ticks(3);
    chk("R4", "feb28 leap", date_word, mk_date(2, 2, 29, 1));
    wr(0, mk_time(23, 59, 58)); ticks(2); ticks(3);
    chk("R4", "feb29 leap", date_word, mk_date(2, 3, 1, 1));

    tag = "R5"; set_dt(0, 12, 31, 0, 23, 59, 58); ticks(3);
    chk("R5", "1970->1971", date_word, mk_date(1, 1, 1, 0));
    set_dt(1, 12, 31, 0, 23, 59, 58); ticks(3);
    chk("R5", "1971->1972 leap", date_word, mk_date(2, 1, 1, 1));
    set_dt(63, 12, 31, 0, 23, 59, 58); ticks(3);
    chk("R5", "2033 wrap", date_word, mk_date(0, 1, 1, 0));

    tag = "R8"; held_d = date_word;
    wr(0, mk_time(1, 2, 3));
    wr(1, mk_date(5, 6, 7, 0));
    chk("R8", "busy after drop", {30'd0, busy}, 32'd1);
    ticks(2);
    chk("R8", "date untouched", date_word, held_d);
    chk("R8", "time committed", time_word, mk_time(1, 2, 3));

    tag = "R9"; wr(1, mk_date(9, 9, 9, 0));
    held_t = time_word; held_d = date_word;
    repeat (20) @(negedge clk);
    chk("R9", "time hold", time_word, held_t);
    chk("R9", "date hold", date_word, held_d);
    chk("R9", "busy hold", {30'd0, busy}, 32'd2);
    ticks(2);
    chk("R7", "date commit", date_word, mk_date(9, 9, 9, 0));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule